// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the device side of a three-wire serial memory: a chip select, a serial clock with a data input, and one data output. While chip select is high, it samples the serial data input on each rising edge of the serial clock. Leading zeros are skipped. A command begins with a 1 start bit, carries a two-bit opcode and an address, and may end with a data word. Reads shift the addressed word out, and the output continues into the following words for as long as the serial clock keeps running. Two bulk commands modify the memory. One sets every bit of the array to ones. The other fills every word with one data value and clears the array first as part of the same cycle.

Both bulk cycles are timed by the block itself. A cycle starts when chip select falls and runs on the system clock, so it needs no serial clock edges. If chip select is raised while a cycle is in progress, the data output reports busy and then ready. A write-enable latch must be set before either bulk command is accepted. The array is an internal register memory with a parameterized word count and width, and both cycle lengths are parameters kept short for simulation. All serial inputs are treated as synchronous to the system clock and are edge-detected against it.

Top module: `uwire_mem_slave`

## Requirements
- R1: After reset the output enable is 0 and the write-enable latch is clear, so a bulk command sent before any enable command starts no cycle.
- R2: Zeros received before the start bit are skipped. The sequence start 1, opcode 1 0 and then the address (MSB first) starts a read. On the rising serial clock edge that takes in the last address bit, the output is driven to 0 as a dummy bit. Each later rising edge drives the next data bit, MSB first.
- R3: If chip select stays high after the last bit of a word, the next rising edges shift out the word at the next address. The address wraps from the top word to word 0.
- R4: The output enable is 0 while chip select is low and while the command and address bits are being received.
- R5: Opcode 0 0 with the two top address bits 1 1 sets the write-enable latch. Opcode 0 0 with the two top address bits 0 0 clears it.
- R6: Opcode 0 0 with the two top address bits 1 0 is the erase-all command. When the latch is set, it starts a cycle of ERASE_CYC system clocks at the falling edge of chip select, and the cycle leaves every bit of the array at 1.
- R7: Opcode 0 0 with the two top address bits 0 1, followed by DATA_W data bits (MSB first), is the write-all command. When the latch is set, it starts a cycle of WRITE_CYC system clocks at the falling edge of chip select. The cycle first sets the array to ones and then stores the data word in every location.
- R8: A bulk command received while the latch is clear starts no cycle and leaves the array unchanged.
- R9: If chip select is high during a cycle, the output is enabled and reads 0 while the cycle runs, then 1 once the cycle has finished.
- R10: While a cycle runs, any command bits that arrive are ignored. The only response is the status output.
- R11: If chip select drops before every bit of a command has been received, the command is dropped and has no effect.
- R12: A cycle completes with the serial clock held idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also times the bulk cycles |
| rst | input | 1 | Synchronous active-high reset |
| serial_cs | input | 1 | Chip select, active high |
| serial_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| serial_din | input | 1 | Serial data input |
| serial_dout | output | 1 | Serial data output: read data or ready/busy status |
| serial_dout_oe | output | 1 | Output enable for serial_dout; 0 models high impedance |

## Verification
The bench aims at the places where a slave of this kind tends to go wrong: the dummy zero bit before the data, the jump into the next word and the wrap from the top address, and the gating of bulk commands by the write-enable latch. A design without the dummy bit would shift every word by one bit, a wrong wrap would return stale or undriven data, and a missing latch check would start a busy cycle the bench sees on the status output. It also measures how long each cycle is busy with the serial clock idle. It sends a full command in the middle of a cycle and drops chip select halfway through a command. A design that decoded the command sent during the cycle would chain a second cycle onto the first, and one that kept a half-received command would act on it.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_READ,
    ST_HOLD,
    ST_STATUS
  } state_t;

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_ERASE,
    PEND_WRITE
  } pend_t;

  // opcode field that follows the start bit
  localparam logic [1:0] OP_READ = 2'b10;
  localparam logic [1:0] OP_MISC = 2'b00;

  // sub-command in the two top address bits when opcode is OP_MISC
  localparam logic [1:0] SUB_ENABLE    = 2'b11;
  localparam logic [1:0] SUB_DISABLE   = 2'b00;
  localparam logic [1:0] SUB_ERASE_ALL = 2'b10;
  localparam logic [1:0] SUB_WRITE_ALL = 2'b01;

endpackage

// File: rtl/uwire_array.sv
module uwire_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // one write port and one registered read port, so the memory maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/uwire_cycle_timer.sv
module uwire_cycle_timer #(
  parameter int ADDR_W    = 4,
  parameter int ERASE_CYC = 40,
  parameter int WRITE_CYC = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_write,
  output logic              busy,
  output logic              fill_we,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              fill_ones
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(WRITE_CYC + 1);

  logic [CW-1:0] cnt;
  logic          is_write;
  logic [CW-1:0] last;
  logic [CW-1:0] second_off;
  logic          in_first, in_second;

  assign last       = is_write ? CW'(WRITE_CYC - 1) : CW'(ERASE_CYC - 1);
  assign second_off = cnt - CW'(ERASE_CYC);
  assign in_first   = cnt < CW'(DEPTH);
  assign in_second  = is_write && (cnt >= CW'(ERASE_CYC)) &&
                      (cnt < CW'(ERASE_CYC + DEPTH));

  // first sweep loads ones; the write cycle then sweeps the data word in
  assign fill_ones = cnt < CW'(ERASE_CYC);
  assign fill_we   = busy && (in_first || in_second);
  assign fill_addr = fill_ones ? cnt[ADDR_W-1:0] : second_off[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      is_write <= 1'b0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      cnt      <= '0;
      is_write <= start_write;
    end else if (busy) begin
      if (cnt == last) busy <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/uwire_mem_slave.sv
module uwire_mem_slave
  import uwire_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int ERASE_CYC = 40,
  parameter int WRITE_CYC = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic serial_cs,
  input  logic serial_clk,
  input  logic serial_din,
  output logic serial_dout,
  output logic serial_dout_oe
);
  localparam int HDR_W = 2 + ADDR_W;
  localparam int MAX_W = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int BW    = $clog2(MAX_W + 1);
  localparam int IW    = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  state_t            state;
  pend_t             pend;
  logic              wen_q;
  logic              cs_q, sclk_q;
  logic [BW-1:0]     bit_cnt;
  logic [HDR_W-1:0]  hdr;
  logic [DATA_W-1:0] wral_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [IW-1:0]     rd_idx;

  logic              sclk_rise, cs_fall;
  logic [HDR_W-1:0]  hdr_next;
  logic [1:0]        op, sub;
  logic [ADDR_W-1:0] hdr_addr;

  logic              cyc_busy, fill_we, fill_ones;
  logic [ADDR_W-1:0] fill_addr;
  logic [DATA_W-1:0] arr_wdata, arr_rdata;

  assign sclk_rise = serial_clk & ~sclk_q;
  assign cs_fall   = cs_q & ~serial_cs;
  assign hdr_next  = {hdr[HDR_W-2:0], serial_din};
  assign op        = hdr_next[HDR_W-1 -: 2];
  assign sub       = hdr_next[ADDR_W-1 -: 2];
  assign hdr_addr  = hdr_next[ADDR_W-1:0];
  assign arr_wdata = fill_ones ? {DATA_W{1'b1}} : wral_data;

  uwire_cycle_timer #(
    .ADDR_W(ADDR_W), .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)
  ) u_timer (
    .clk(clk), .rst(rst),
    .start(cs_fall && (pend != PEND_NONE)),
    .start_write(pend == PEND_WRITE),
    .busy(cyc_busy), .fill_we(fill_we),
    .fill_addr(fill_addr), .fill_ones(fill_ones)
  );

  uwire_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(fill_we), .waddr(fill_addr), .wdata(arr_wdata),
    .raddr(rd_addr), .rdata(arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      pend           <= PEND_NONE;
      wen_q          <= 1'b0;
      cs_q           <= 1'b0;
      sclk_q         <= 1'b0;
      bit_cnt        <= '0;
      hdr            <= '0;
      wral_data      <= '0;
      rd_addr        <= '0;
      rd_idx         <= '0;
      serial_dout    <= 1'b0;
      serial_dout_oe <= 1'b0;
    end else begin
      cs_q   <= serial_cs;
      sclk_q <= serial_clk;
      if (!serial_cs) begin
        // deselect drops any partial command and any pending bulk request
        state          <= ST_IDLE;
        pend           <= PEND_NONE;
        bit_cnt        <= '0;
        serial_dout    <= 1'b0;
        serial_dout_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (cyc_busy) begin
              state          <= ST_STATUS;
              serial_dout    <= 1'b0;
              serial_dout_oe <= 1'b1;
            end else if (sclk_rise && serial_din) begin
              state   <= ST_HDR;
              bit_cnt <= '0;
            end
          end
          ST_HDR: if (sclk_rise) begin
            hdr <= hdr_next;
            if (bit_cnt == BW'(HDR_W - 1)) begin
              bit_cnt <= '0;
              state   <= ST_HOLD;
              if (op == OP_READ) begin
                state          <= ST_READ;
                rd_addr        <= hdr_addr;
                rd_idx         <= IW'(DATA_W - 1);
                serial_dout    <= 1'b0;
                serial_dout_oe <= 1'b1;
              end else if (op == OP_MISC) begin
                case (sub)
                  SUB_ENABLE:    wen_q <= 1'b1;
                  SUB_DISABLE:   wen_q <= 1'b0;
                  SUB_ERASE_ALL: if (wen_q) pend <= PEND_ERASE;
                  default:       if (wen_q) state <= ST_DATA;
                endcase
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_DATA: if (sclk_rise) begin
            wral_data <= {wral_data[DATA_W-2:0], serial_din};
            if (bit_cnt == BW'(DATA_W - 1)) begin
              pend  <= PEND_WRITE;
              state <= ST_HOLD;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_READ: if (sclk_rise) begin
            serial_dout <= arr_rdata[rd_idx];
            if (rd_idx == '0) begin
              rd_idx  <= IW'(DATA_W - 1);
              rd_addr <= rd_addr + 1'b1;
            end else begin
              rd_idx <= rd_idx - 1'b1;
            end
          end
          ST_STATUS: begin
            serial_dout_oe <= 1'b1;
            serial_dout    <= ~cyc_busy;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/uwire_mem_slave_chk.sv
module uwire_mem_slave_chk #(
  parameter int ERASE_CYC = 40,
  parameter int WRITE_CYC = 80
) (
  input logic clk,
  input logic rst,
  input logic serial_cs,
  input logic serial_dout,
  input logic serial_dout_oe,
  input logic busy,
  input logic wen
);
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_len <= 0;
    else              run_len <= run_len + 1;
  end

  p_oe_off_when_deselected_r4: assert property (@(posedge clk) disable iff (rst)
    !serial_cs |=> !serial_dout_oe);

  p_first_driven_bit_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(serial_dout_oe) |-> !serial_dout);

  p_cycle_starts_deselected_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !serial_cs);

  p_cycle_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> wen);

  p_cycle_length_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == ERASE_CYC || run_len == WRITE_CYC));

  p_busy_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && serial_dout_oe) |-> !serial_dout);

endmodule

bind uwire_mem_slave uwire_mem_slave_chk #(
  .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)
) u_chk (
  .clk(clk), .rst(rst), .serial_cs(serial_cs),
  .serial_dout(serial_dout), .serial_dout_oe(serial_dout_oe),
  .busy(cyc_busy), .wen(wen_q)
);

// File: tb/uwire_mem_slave_tb.sv
`timescale 1ns/1ps
module uwire_mem_slave_tb;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int ERASE_CYC = 40;
  localparam int WRITE_CYC = 80;
  localparam int NV = 4;
  localparam logic [7:0] VALS  [NV] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
  localparam logic [3:0] ADDRS [NV] = '{4'd0, 4'd7, 4'd15, 4'd9};

  logic clk = 0, rst = 1, cs = 0, sclk = 0, din = 0;
  logic dout, dout_oe;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uwire_mem_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) u_dut (
    .clk(clk), .rst(rst), .serial_cs(cs), .serial_clk(sclk),
    .serial_din(din), .serial_dout(dout), .serial_dout_oe(dout_oe));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    din = b; clks(4); sclk = 1; clks(4); sclk = 0;
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [3:0] a);
    cs = 1; clks(2);
    send_bit(0); send_bit(0); send_bit(1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 3; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic deselect();
    cs = 0; din = 0; clks(4);
  endtask

  task automatic wen_cmd(input logic on);
    send_cmd(2'b00, on ? 4'b1100 : 4'b0000); deselect();
  endtask

  task automatic wral(input logic [7:0] v);
    send_cmd(2'b00, 4'b0100);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  // drops CS, raises it again and polls status until ready; returns cycles
  task automatic run_cycle(input string req, output int n);
    cs = 0; din = 0; n = 0;
    repeat (3) begin @(negedge clk); n++; end
    cs = 1; @(negedge clk); n++;
    chk({req, "/R9 busy oe"}, dout_oe, 1);
    chk({req, "/R9 busy level"}, dout, 0);
    while (dout !== 1'b1 && n < 400) begin @(negedge clk); n++; end
    chk({req, "/R9 ready level"}, dout, 1);
    deselect();
  endtask

  task automatic read_word(input string req, output logic [7:0] w);
    for (int i = 7; i >= 0; i--) begin send_bit(0); w[i] = dout; end
  endtask

  task automatic read_check(input logic [3:0] a, input logic [7:0] exp, input string req);
    logic [7:0] w;
    cs = 1; clks(2);
    send_bit(0); send_bit(1); send_bit(1);
    chk("R4 oe during command", dout_oe, 0);
    send_bit(0);
    for (int i = 3; i >= 0; i--) send_bit(a[i]);
    chk("R2 dummy oe", dout_oe, 1);
    chk("R2 dummy bit", dout, 0);
    read_word(req, w);
    chk({req, " word"}, w, exp);
    read_word(req, w);
    chk({"R3 next word ", req}, w, exp);
    deselect();
    chk("R4 oe deselected", dout_oe, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    clks(3); rst = 0; clks(2);
    chk("R1 reset oe", dout_oe, 0);
    // R1/R8: bulk write before any enable starts nothing
    wral(8'h5A); cs = 0; clks(4); cs = 1; clks(3);
    chk("R1 no cycle without enable", dout_oe, 0);
    deselect();

    // vector table: fill the array with each value and read it back
    for (int k = 0; k < NV; k++) begin
      wen_cmd(1);
      wral(VALS[k]);
      run_cycle("R7", n);
      chk("R7 write cycle length", int'(n >= WRITE_CYC && n <= WRITE_CYC + 4), 1);
      read_check(ADDRS[k], VALS[k], "R7");
    end

    // R6 erase-all, R12 no serial clock during cycle
    wen_cmd(1);
    send_cmd(2'b00, 4'b1000);
    run_cycle("R6", n);
    chk("R12 erase cycle length", int'(n >= ERASE_CYC && n <= ERASE_CYC + 4), 1);
    read_check(4'd3, 8'hFF, "R6");

    // R5/R8: disable then erase-all is ignored
    wral(8'h12); run_cycle("R7", n);
    wen_cmd(0);
    send_cmd(2'b00, 4'b1000); cs = 0; clks(4); cs = 1; clks(3);
    chk("R8 no cycle after disable", dout_oe, 0);
    deselect();
    read_check(4'd5, 8'h12, "R5/R8");

    // R10: command sent during a cycle is ignored
    wen_cmd(1);
    wral(8'h77);
    cs = 0; clks(3); cs = 1;
    send_cmd(2'b00, 4'b1000);
    chk("R10 status during cycle", dout_oe, 1);
    cs = 0; clks(WRITE_CYC + 10);
    cs = 1; clks(3);
    chk("R10 no chained cycle", dout_oe, 0);
    deselect();
    read_check(4'd1, 8'h77, "R10");

    // R11: partial command aborted by deselect
    cs = 1; clks(2);
    send_bit(1); send_bit(0); send_bit(0); send_bit(1);
    deselect();
    cs = 1; clks(3);
    chk("R11 aborted erase", dout_oe, 0);
    deselect();
    read_check(4'd14, 8'h77, "R11");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule